// File: doc/BRIEF.md
# Two-Level Interrupt Entry Sequencer

This block sits beside the control path of a small 8/16-bit processor core. It performs the entry into an interrupt service routine. Two level-sensitive request lines come in: a fast one and a normal one. While idle, the block compares them against two mask bits in the condition-code byte and accepts at most one request. It then writes a stack frame one byte per cycle, reads a 16-bit vector from memory and hands the core a new program counter, the updated condition-code byte, the final stack pointer and the cycle cost to charge.

The fast request saves a short frame: the program counter and the flags. The normal request saves every programmer-visible register. One bit of the pushed flags byte tells a later return instruction which of the two frames is on the stack. If a preceding wait instruction already saved the state, the block skips stacking and only performs the vector fetch. Any active request line releases a sync-style wait, whether or not that request is masked.

Top module: `irq_entry_seq`

## Requirements
- R1: `sync_release` is high in every cycle where `sync_wait_in` is high and at least one request line is high. This holds regardless of the mask bits and of `busy`.
- R2: While idle, the fast request is accepted when `req_fast` is high and flag bit 6 is clear. Otherwise the normal request is accepted when `req_norm` is high and flag bit 4 is clear. Otherwise nothing happens and `busy` stays low.
- R3: An accepted fast request without a saved state pushes three bytes: PC low, PC high, then the flags with bit 7 cleared. The reported cost is 10.
- R4: An accepted normal request without a saved state pushes twelve bytes: PC, U, Y, X (each low byte then high byte), then DP, B, A and the flags with bit 7 set. The reported cost is 19.
- R5: When `wait_saved_in` is high at acceptance, no byte is pushed and the reported cost is 7. `wait_saved_clr` is high during the acceptance cycle only.
- R6: Pushes start in the cycle after acceptance and occur in consecutive cycles. Byte k (counting from 0) goes to address `sp_in`-1-k, with 16-bit wrap-around. `sp_out` equals `sp_in` minus the number of pushed bytes.
- R7: After the pushes, `vec_rd` is high for two consecutive cycles: first at address V, then at V+1. V is 0xFFF6 for the fast request and 0xFFF8 for the normal one. `vec_rdata` answers one cycle after each read. `pc_new` is {byte at V, byte at V+1}.
- R8: In the cycle after the second read, `pc_load` and `cc_we` are high for one cycle and `cost` is valid. `cc_out` is the pushed flags byte (or `cc_in` when the state was already saved) with bit 4 set, and with bit 6 also set for a fast request. Exactly one of `ack_fast`/`ack_norm` pulses, matching the served request.
- R9: `busy` is high from the cycle after acceptance through the `pc_load` cycle and low in the cycle after it. Request lines have no effect on the outputs while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_fast | input | 1 | Fast interrupt request, level |
| req_norm | input | 1 | Normal interrupt request, level |
| cc_in | input | 8 | Current condition-code byte |
| wait_saved_in | input | 1 | State already stacked by a wait instruction |
| sync_wait_in | input | 1 | Core is in a sync-style wait |
| sp_in | input | 16 | System stack pointer |
| pc_in | input | 16 | Program counter to save |
| u_in | input | 16 | User stack pointer to save |
| y_in | input | 16 | Index Y to save |
| x_in | input | 16 | Index X to save |
| dp_in | input | 8 | Direct page register to save |
| b_in | input | 8 | Accumulator B to save |
| a_in | input | 8 | Accumulator A to save |
| sync_release | output | 1 | Leave the sync wait |
| wait_saved_clr | output | 1 | Clear the saved-state flag |
| push_we | output | 1 | Stack byte write strobe |
| push_addr | output | 16 | Stack byte address |
| push_data | output | 8 | Stack byte data |
| vec_rd | output | 1 | Vector read strobe |
| vec_addr | output | 16 | Vector read address |
| vec_rdata | input | 8 | Vector read data, one cycle after `vec_rd` |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | 16 | Fetched vector |
| cc_we | output | 1 | Write `cc_out` into the flags |
| cc_out | output | 8 | Updated condition-code byte |
| sp_out | output | 16 | Stack pointer after the pushes |
| cost | output | 5 | Cycle cost of the entry |
| ack_fast | output | 1 | Fast request served |
| ack_norm | output | 1 | Normal request served |
| busy | output | 1 | Entry sequence in progress |

## Verification
The hardest situation to reach is a request that changes while an entry is already under way, because the block then has to ignore it. The stimulus raises both request lines during the vector reads of a fast entry. It then checks the remaining cycles against the undisturbed frame. After `pc_load`, the masks written back by the block are applied to `cc_in`, as the core would do. This leads into cases where a still-asserted but now-masked line must not start a second entry. The saved-state path, which has no push phase, and a stack pointer near zero that wraps during pushes are driven deliberately as well.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int DW        = 8;
    localparam int AW        = 16;
    localparam int NWORDS    = 4;
    localparam int NBYTEREGS = 3;
    localparam int FRAME_MAX = 2 * NWORDS + NBYTEREGS + 1;
    localparam int FAST_LEN  = 3;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    localparam int BIT_ENTIRE = 7;
    localparam int BIT_FMASK  = 6;
    localparam int BIT_NMASK  = 4;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PUSH   = 3'd1,
        ST_VEC_HI = 3'd2,
        ST_VEC_LO = 3'd3,
        ST_LOAD   = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e                    st;
        logic                          fast;
        logic                          saved;
        logic [CNT_W-1:0]              cnt;
        logic [CNT_W-1:0]              num;
        word_t                         sp;
        logic [FRAME_MAX-1:0][DW-1:0]  frame;
        byte_t                         cc;
        byte_t                         vhi;
    } seq_t;

endpackage

// File: rtl/irq_entry_arbiter.sv
module irq_entry_arbiter (
    input  logic req_fast,
    input  logic req_norm,
    input  logic fmask,
    input  logic nmask,
    input  logic busy,
    input  logic sync_wait_in,
    output logic take,
    output logic take_fast,
    output logic sync_release
);

    logic take_norm;

    always_comb begin
        take_fast    = !busy && req_fast && !fmask;
        take_norm    = !busy && !take_fast && req_norm && !nmask;
        take         = take_fast || take_norm;
        sync_release = sync_wait_in && (req_fast || req_norm);
    end

endmodule

// File: rtl/irq_frame_builder.sv
module irq_frame_builder
    import irq_entry_pkg::*;
(
    input  logic                         sel_fast,
    input  logic                         saved,
    input  word_t                        pc,
    input  word_t                        u,
    input  word_t                        y,
    input  word_t                        x,
    input  byte_t                        dp,
    input  byte_t                        b,
    input  byte_t                        a,
    input  byte_t                        cc,
    output logic [FRAME_MAX-1:0][DW-1:0] frame,
    output logic [CNT_W-1:0]             count,
    output byte_t                        cc_final
);

    localparam int TAIL = 2 * NWORDS;

    word_t                         words [NWORDS];
    logic [FRAME_MAX-1:0][DW-1:0]  norm_f;
    logic [FRAME_MAX-1:0][DW-1:0]  fast_f;
    byte_t                         cc_full;
    byte_t                         cc_short;
    byte_t                         fmask_b;
    byte_t                         nmask_b;
    byte_t                         entire_b;

    assign words[0] = pc;
    assign words[1] = u;
    assign words[2] = y;
    assign words[3] = x;

    assign fmask_b  = byte_t'(1) << BIT_FMASK;
    assign nmask_b  = byte_t'(1) << BIT_NMASK;
    assign entire_b = byte_t'(1) << BIT_ENTIRE;
    assign cc_full  = cc | entire_b;
    assign cc_short = cc & ~entire_b;

    // Full frame: each word low byte first, then the byte registers, flags last
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign norm_f[2*w]   = words[w][DW-1:0];
        assign norm_f[2*w+1] = words[w][AW-1:DW];
    end
    assign norm_f[TAIL]   = dp;
    assign norm_f[TAIL+1] = b;
    assign norm_f[TAIL+2] = a;
    assign norm_f[TAIL+3] = cc_full;

    // Short frame: PC low, PC high, flags; unused slots zero
    assign fast_f[0] = pc[DW-1:0];
    assign fast_f[1] = pc[AW-1:DW];
    assign fast_f[2] = cc_short;
    for (genvar k = FAST_LEN; k < FRAME_MAX; k++) begin : g_pad
        assign fast_f[k] = '0;
    end

    always_comb begin
        if (saved) begin
            frame    = '0;
            count    = '0;
            cc_final = cc | nmask_b | (sel_fast ? fmask_b : '0);
        end else if (sel_fast) begin
            frame    = fast_f;
            count    = CNT_W'(FAST_LEN);
            cc_final = cc_short | fmask_b | nmask_b;
        end else begin
            frame    = norm_f;
            count    = CNT_W'(FRAME_MAX);
            cc_final = cc_full | nmask_b;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter logic [15:0] FAST_VEC   = 16'hFFF6,
    parameter logic [15:0] NORM_VEC   = 16'hFFF8,
    parameter int          COST_FAST  = 10,
    parameter int          COST_NORM  = 19,
    parameter int          COST_SAVED = 7,
    parameter int          COST_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fast,
    input  logic              req_norm,
    input  logic [7:0]        cc_in,
    input  logic              wait_saved_in,
    input  logic              sync_wait_in,
    input  logic [15:0]       sp_in,
    input  logic [15:0]       pc_in,
    input  logic [15:0]       u_in,
    input  logic [15:0]       y_in,
    input  logic [15:0]       x_in,
    input  logic [7:0]        dp_in,
    input  logic [7:0]        b_in,
    input  logic [7:0]        a_in,
    output logic              sync_release,
    output logic              wait_saved_clr,
    output logic              push_we,
    output logic [15:0]       push_addr,
    output logic [7:0]        push_data,
    output logic              vec_rd,
    output logic [15:0]       vec_addr,
    input  logic [7:0]        vec_rdata,
    output logic              pc_load,
    output logic [15:0]       pc_new,
    output logic              cc_we,
    output logic [7:0]        cc_out,
    output logic [15:0]       sp_out,
    output logic [COST_W-1:0] cost,
    output logic              ack_fast,
    output logic              ack_norm,
    output logic              busy
);

    seq_t                         q;
    seq_t                         d;
    logic                         take;
    logic                         take_fast;
    logic [FRAME_MAX-1:0][DW-1:0] frm_bytes;
    logic [CNT_W-1:0]             frm_count;
    byte_t                        frm_cc;
    word_t                        vec_base;

    assign busy   = (q.st != ST_IDLE);
    assign cc_out = q.cc;
    assign sp_out = q.sp;

    irq_entry_arbiter u_arb (
        .req_fast     (req_fast),
        .req_norm     (req_norm),
        .fmask        (cc_in[BIT_FMASK]),
        .nmask        (cc_in[BIT_NMASK]),
        .busy         (busy),
        .sync_wait_in (sync_wait_in),
        .take         (take),
        .take_fast    (take_fast),
        .sync_release (sync_release)
    );

    irq_frame_builder u_frame (
        .sel_fast (take_fast),
        .saved    (wait_saved_in),
        .pc       (pc_in),
        .u        (u_in),
        .y        (y_in),
        .x        (x_in),
        .dp       (dp_in),
        .b        (b_in),
        .a        (a_in),
        .cc       (cc_in),
        .frame    (frm_bytes),
        .count    (frm_count),
        .cc_final (frm_cc)
    );

    always_comb begin
        d              = q;
        wait_saved_clr = 1'b0;
        push_we        = 1'b0;
        push_addr      = '0;
        push_data      = '0;
        vec_rd         = 1'b0;
        vec_addr       = '0;
        pc_load        = 1'b0;
        pc_new         = '0;
        cc_we          = 1'b0;
        cost           = '0;
        ack_fast       = 1'b0;
        ack_norm       = 1'b0;
        vec_base       = q.fast ? FAST_VEC : NORM_VEC;

        unique case (q.st)
            ST_IDLE: begin
                if (take) begin
                    d.st           = wait_saved_in ? ST_VEC_HI : ST_PUSH;
                    d.fast         = take_fast;
                    d.saved        = wait_saved_in;
                    d.cnt          = '0;
                    d.num          = frm_count;
                    d.sp           = sp_in;
                    d.frame        = frm_bytes;
                    d.cc           = frm_cc;
                    d.vhi          = '0;
                    wait_saved_clr = wait_saved_in;
                end
            end
            ST_PUSH: begin
                push_we   = 1'b1;
                push_addr = q.sp - 16'd1;
                push_data = q.frame[q.cnt];
                d.sp      = q.sp - 16'd1;
                d.cnt     = q.cnt + 1'b1;
                if (q.cnt == q.num - 1'b1) begin
                    d.st = ST_VEC_HI;
                end
            end
            ST_VEC_HI: begin
                vec_rd   = 1'b1;
                vec_addr = vec_base;
                d.st     = ST_VEC_LO;
            end
            ST_VEC_LO: begin
                vec_rd   = 1'b1;
                vec_addr = vec_base + 16'd1;
                d.vhi    = vec_rdata;
                d.st     = ST_LOAD;
            end
            ST_LOAD: begin
                pc_load  = 1'b1;
                pc_new   = {q.vhi, vec_rdata};
                cc_we    = 1'b1;
                ack_fast = q.fast;
                ack_norm = !q.fast;
                if (q.saved) begin
                    cost = COST_W'(COST_SAVED);
                end else if (q.fast) begin
                    cost = COST_W'(COST_FAST);
                end else begin
                    cost = COST_W'(COST_NORM);
                end
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R6: consecutive pushes walk downward by one byte
    a_r6_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push_we && $past(push_we)) |-> (push_addr == $past(push_addr) - 16'd1));

    // R7: the vector is read as a pair of adjacent bytes
    a_r7_vec_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !$past(vec_rd)) |=> (vec_rd && vec_addr == $past(vec_addr) + 16'd1));

    // R8: an acknowledge comes only with the PC load and only on one line
    a_r8_ack_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fast || ack_norm) |-> (pc_load && $onehot0({ack_fast, ack_norm})));

    // R8: a served fast request leaves both masks set
    a_r8_fast_masks: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fast |-> (cc_out[BIT_FMASK] && cc_out[BIT_NMASK]));

    // R5: a saved-state entry goes straight to the vector reads
    a_r5_saved_skip: assert property (@(posedge clk) disable iff (!rst_n)
        wait_saved_clr |=> (!push_we && vec_rd));

    // R9: busy ends right after the PC load
    a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    // R9: no bus activity outside a sequence
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!push_we && !vec_rd && !pc_load));

endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_fast = 1'b0, req_norm = 1'b0;
    logic [7:0]  cc_in = 8'h00;
    logic        wait_saved_in = 1'b0, sync_wait_in = 1'b0;
    logic [15:0] sp_in = 16'h0400, pc_in = 16'h1234, u_in = 16'h5678;
    logic [15:0] y_in = 16'h9ABC, x_in = 16'hDEF0;
    logic [7:0]  dp_in = 8'h11, b_in = 8'h22, a_in = 8'h33;
    logic        sync_release, wait_saved_clr, push_we, vec_rd, pc_load, cc_we;
    logic        ack_fast, ack_norm, busy;
    logic [15:0] push_addr, vec_addr, pc_new, sp_out;
    logic [7:0]  push_data, cc_out;
    logic [7:0]  vec_rdata = 8'h00;
    logic [4:0]  cost;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .req_fast(req_fast), .req_norm(req_norm),
        .cc_in(cc_in), .wait_saved_in(wait_saved_in), .sync_wait_in(sync_wait_in),
        .sp_in(sp_in), .pc_in(pc_in), .u_in(u_in), .y_in(y_in), .x_in(x_in),
        .dp_in(dp_in), .b_in(b_in), .a_in(a_in),
        .sync_release(sync_release), .wait_saved_clr(wait_saved_clr),
        .push_we(push_we), .push_addr(push_addr), .push_data(push_data),
        .vec_rd(vec_rd), .vec_addr(vec_addr), .vec_rdata(vec_rdata),
        .pc_load(pc_load), .pc_new(pc_new), .cc_we(cc_we), .cc_out(cc_out),
        .sp_out(sp_out), .cost(cost), .ack_fast(ack_fast), .ack_norm(ack_norm),
        .busy(busy)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'h3C;
    endfunction

    // Vector memory with one cycle of read latency
    always_ff @(posedge clk) begin
        if (vec_rd) vec_rdata <= memf(vec_addr);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Drive one scenario starting just after a falling edge; compare every cycle
    task automatic run_case(input logic rf, input logic rn, input logic ws,
                            input logic sw, input logic disturb,
                            input logic [7:0] ccv, input logic [15:0] spv,
                            input logic exp_take, input logic exp_fast);
        logic [7:0]  frame_q[$];
        logic [7:0]  ccfin;
        logic [15:0] vbase;
        logic [4:0]  ecost;
        req_fast = rf; req_norm = rn; wait_saved_in = ws; sync_wait_in = sw;
        cc_in = ccv; sp_in = spv;
        #1;
        chk(sync_release == (sw & (rf | rn)), "R1", "sync_release",
            32'(sync_release), 32'(sw & (rf | rn)));
        chk(wait_saved_clr == (exp_take & ws), "R5", "wait_saved_clr at accept",
            32'(wait_saved_clr), 32'(exp_take & ws));
        chk(busy == 1'b0, "R9", "busy before accept", 32'(busy), 0);
        if (!exp_take) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(!busy && !push_we && !vec_rd, "R2", "masked request ignored",
                    {29'd0, busy, push_we, vec_rd}, 0);
            end
            req_fast = 1'b0; req_norm = 1'b0; sync_wait_in = 1'b0;
            return;
        end
        if (!ws) begin
            frame_q.push_back(pc_in[7:0]);
            frame_q.push_back(pc_in[15:8]);
            if (exp_fast) begin
                frame_q.push_back(ccv & 8'h7F);
            end else begin
                frame_q.push_back(u_in[7:0]); frame_q.push_back(u_in[15:8]);
                frame_q.push_back(y_in[7:0]); frame_q.push_back(y_in[15:8]);
                frame_q.push_back(x_in[7:0]); frame_q.push_back(x_in[15:8]);
                frame_q.push_back(dp_in); frame_q.push_back(b_in);
                frame_q.push_back(a_in); frame_q.push_back(ccv | 8'h80);
            end
        end
        ccfin = (ws ? ccv : (exp_fast ? (ccv & 8'h7F) : (ccv | 8'h80)))
                | (exp_fast ? 8'h50 : 8'h10);
        vbase = exp_fast ? 16'hFFF6 : 16'hFFF8;
        ecost = ws ? 5'd7 : (exp_fast ? 5'd10 : 5'd19);
        for (int i = 0; i < frame_q.size(); i++) begin
            @(negedge clk);
            chk(push_we && busy && !vec_rd, exp_fast ? "R3" : "R4", "push strobe",
                {29'd0, push_we, busy, vec_rd}, 32'h6);
            chk(push_addr == spv - 16'(i + 1), "R6", "push address",
                32'(push_addr), 32'(spv - 16'(i + 1)));
            chk(push_data == frame_q[i], exp_fast ? "R3" : "R4", "push byte",
                32'(push_data), 32'(frame_q[i]));
        end
        @(negedge clk);
        chk(vec_rd && !push_we && vec_addr == vbase, "R7", "first vector read",
            {vec_rd, push_we, 14'd0, vec_addr}, {2'b10, 14'd0, vbase});
        if (disturb) begin
            req_fast = 1'b1; req_norm = 1'b1;
        end
        @(negedge clk);
        chk(vec_rd && vec_addr == vbase + 16'd1, "R7", "second vector read",
            {vec_rd, 15'd0, vec_addr}, {1'b1, 15'd0, vbase + 16'd1});
        @(negedge clk);
        chk(pc_load && cc_we && busy, "R8", "load strobes",
            {29'd0, pc_load, cc_we, busy}, 32'h7);
        chk(pc_new == {memf(vbase), memf(vbase + 16'd1)}, "R7", "vector value",
            32'(pc_new), 32'({memf(vbase), memf(vbase + 16'd1)}));
        chk(cc_out == ccfin, "R8", "flags written back", 32'(cc_out), 32'(ccfin));
        chk(cost == ecost, ws ? "R5" : (exp_fast ? "R3" : "R4"), "cost",
            32'(cost), 32'(ecost));
        chk(ack_fast == exp_fast && ack_norm == !exp_fast, "R8", "acknowledge line",
            {30'd0, ack_fast, ack_norm}, {30'd0, exp_fast, !exp_fast});
        chk(sp_out == spv - 16'(frame_q.size()), "R6", "final stack pointer",
            32'(sp_out), 32'(spv - 16'(frame_q.size())));
        req_fast = 1'b0; req_norm = 1'b0; wait_saved_in = 1'b0; sync_wait_in = 1'b0;
        cc_in = ccfin;
        @(negedge clk);
        chk(!busy && !pc_load && !ack_fast && !ack_norm, "R9", "idle after load",
            {28'd0, busy, pc_load, ack_fast, ack_norm}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !push_we && !vec_rd && !pc_load && !ack_fast && !ack_norm,
            "R9", "reset state",
            {26'd0, busy, push_we, vec_rd, pc_load, ack_fast, ack_norm}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: normal request, sync wait released
        run_case(0, 1, 0, 1, 0, 8'h00, 16'h0400, 1, 0);
        // R3: fast request, flag bit 7 cleared in the pushed byte
        pc_in = 16'hA55A;
        run_case(1, 0, 0, 0, 0, 8'h85, 16'h0200, 1, 1);
        // R2: both lines, fast wins; R9: disturbance while busy
        run_case(1, 1, 0, 0, 1, 8'h00, 16'h0100, 1, 1);
        // R2: fast masked, normal served
        u_in = 16'h0F0F; x_in = 16'h8001;
        run_case(1, 1, 0, 0, 0, 8'h40, 16'h3000, 1, 0);
        // R2, R1: both masked, sync still released
        run_case(1, 1, 0, 1, 0, 8'h50, 16'h3000, 0, 0);
        // R2: fast alone masked
        run_case(1, 0, 0, 0, 0, 8'h40, 16'h3000, 0, 0);
        // R2: normal masked, fast unmasked
        run_case(1, 1, 0, 0, 0, 8'h10, 16'h2000, 1, 1);
        // R5: state already saved, normal and fast
        run_case(0, 1, 1, 0, 0, 8'h80, 16'h1000, 1, 0);
        run_case(1, 0, 1, 1, 0, 8'h00, 16'h1000, 1, 1);
        // R6: stack pointer wraps through zero
        dp_in = 8'hFE; a_in = 8'h01;
        run_case(0, 1, 0, 0, 0, 8'h2B, 16'h0003, 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule